// File: doc/BRIEF.md
# Segmented Virtual Address Translator with Fault Capture

This block translates a 32-bit virtual address for a processor's memory pipeline. Each request carries a user-mode flag, an error-level flag and a load/store flag. The block sorts the address into one of a few fixed regions by its top bits. Two kernel windows are translated directly by removing the window base. The other regions are sent to an external page-table lookup port, and the status that port returns decides the outcome. User-mode requests to the upper half of the space are rejected as address errors.

The translation result leaves on a response port one clock after the request. When a request fails, a fault strobe loads three architectural registers: the faulting address, a context word holding the page-pair number under a base field, and an entry-high word holding the page-pair number above the current address-space identifier. The context base and the identifier are loaded through two small write ports. The page-table array itself is not part of the block.

Top module: `seg_xlate_unit`

## Requirements
- R1: A request with `req_user`=1 and address bit 31 set is an address error: code 4 for a load or code 5 for a store. No lookup is requested.
- R2: A request below 0x80000000 with `req_error_lvl`=0 raises `tlb_req_o` with `tlb_vaddr_o` equal to the address, and its result comes from the lookup status. This applies in user mode as well.
- R3: A request below 0x80000000 with `req_error_lvl`=1 translates to the same address. No lookup is requested and the lookup status is ignored.
- R4: Addresses 0x80000000..0x9FFFFFFF translate to the address minus 0x80000000. Addresses 0xA0000000..0xBFFFFFFF translate to the address minus 0xA0000000. Neither raises `tlb_req_o`, and `tlb_status_i` has no effect on them.
- R5: In kernel mode, addresses 0xC0000000 and above raise `tlb_req_o` and take their result from the lookup status.
- R6: Lookup status 2'b00 (hit) gives a successful response with the physical address taken from `tlb_paddr_i`. Status 2'b01 (no match) and 2'b10 (invalid) give code 3 for a store and code 2 for a load.
- R7: Lookup status 2'b11 (write to a clean page) gives code 1.
- R8: `resp_valid` is high for exactly the cycle after a cycle with `req_valid`=1. `resp_fault` and `resp_code` describe that request. On a fault, `resp_paddr` is 0 and on a success `resp_code` is 0.
- R9: On a fault, `badaddr_o` takes the full faulting address on the same edge that raises the response.
- R10: `context_o` is {base[8:0], vaddr[31:13], 4'b0000}. A fault loads the middle field, and `ctx_base_we` loads the base from `ctx_base_wdata`.
- R11: `entryhi_o` is {vaddr[31:13], 5'b00000, asid[7:0]}. A fault loads the upper field and keeps the identifier, and `asid_we` loads the identifier from `asid_wdata`.
- R12: The fault registers change only on a cycle with a fault strobe, which means a valid request that fails. Successful or idle cycles leave `badaddr_o` and the fault-loaded fields unchanged.
- R13: After reset, `resp_valid`, `badaddr_o`, `context_o` and `entryhi_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | Request issued in user mode |
| req_error_lvl | input | 1 | Error-level flag (low region unmapped) |
| req_store | input | 1 | 1 = store, 0 = load |
| tlb_req_o | output | 1 | Lookup needed for this request |
| tlb_vaddr_o | output | 32 | Address presented to the lookup |
| tlb_status_i | input | 2 | Lookup status: 00 hit, 01 no match, 10 invalid, 11 clean page written |
| tlb_paddr_i | input | 32 | Physical address from the lookup on a hit |
| ctx_base_we | input | 1 | Load context base field |
| ctx_base_wdata | input | 9 | New context base |
| asid_we | input | 1 | Load address-space identifier |
| asid_wdata | input | 8 | New identifier |
| resp_valid | output | 1 | Response present |
| resp_fault | output | 1 | Request failed |
| resp_code | output | 5 | Exception code (0 when no fault) |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| badaddr_o | output | 32 | Last faulting address |
| context_o | output | 32 | Context word |
| entryhi_o | output | 32 | Entry-high word |

## Verification
A wrong region decode shows one cycle later as a wrong response code or physical address. For the mapped regions it shows earlier still, in the same cycle, as a wrong `tlb_req_o`. A wrong fault strobe or a register captured on the wrong cycle shows on the edge of the failing request as a wrong `badaddr_o`, `context_o` or `entryhi_o`. It can also show later: a successful translation after a fault must leave those three outputs unchanged, so a stray update is caught on the next successful request. Each vector is followed by a comparison of all three fault words against the bench's model, so a stray update is caught within one request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [1:0] {
    REG_BAD    = 2'd0,
    REG_MAPPED = 2'd1,
    REG_DIRECT = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    LK_HIT     = 2'b00,
    LK_NOMATCH = 2'b01,
    LK_INVALID = 2'b10,
    LK_CLEAN   = 2'b11
  } lookup_e;

  localparam logic [CODE_W-1:0] EXC_NONE  = 5'd0;
  localparam logic [CODE_W-1:0] EXC_CLEAN = 5'd1;
  localparam logic [CODE_W-1:0] EXC_TLB_L = 5'd2;
  localparam logic [CODE_W-1:0] EXC_TLB_S = 5'd3;
  localparam logic [CODE_W-1:0] EXC_ADR_L = 5'd4;
  localparam logic [CODE_W-1:0] EXC_ADR_S = 5'd5;
endpackage

// File: rtl/seg_region_decode.sv
module seg_region_decode
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W = 32
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            user,
  input  logic            error_lvl,
  output region_e         region,
  output logic [VA_W-1:0] direct_paddr
);
  localparam int unsigned WIN_LSB = VA_W - 3;

  logic [2:0] top3;
  assign top3 = vaddr[VA_W-1:WIN_LSB];

  always_comb begin
    region       = REG_MAPPED;
    direct_paddr = '0;
    if (user && vaddr[VA_W-1]) begin
      region = REG_BAD;
    end else if (!vaddr[VA_W-1]) begin
      if (error_lvl) begin
        region       = REG_DIRECT;
        direct_paddr = vaddr;
      end
    end else if (top3 == 3'b100 || top3 == 3'b101) begin
      // both kernel windows drop the three top bits
      region       = REG_DIRECT;
      direct_paddr = {3'b000, vaddr[WIN_LSB-1:0]};
    end
  end

  always_comb begin
    if (region == REG_DIRECT && vaddr[VA_W-1])
      assert_window_kernel_R4: assert (!user);
  end
endmodule

// File: rtl/seg_outcome.sv
module seg_outcome
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W = 32
) (
  input  region_e           region,
  input  logic              store,
  input  logic [VA_W-1:0]   direct_paddr,
  input  logic [1:0]        lk_status,
  input  logic [VA_W-1:0]   lk_paddr,
  output logic              fault,
  output logic [CODE_W-1:0] code,
  output logic [VA_W-1:0]   paddr
);
  always_comb begin
    fault = 1'b0;
    code  = EXC_NONE;
    paddr = '0;
    unique case (region)
      REG_BAD: begin
        fault = 1'b1;
        code  = store ? EXC_ADR_S : EXC_ADR_L;
      end
      REG_DIRECT: paddr = direct_paddr;
      default: begin
        unique case (lookup_e'(lk_status))
          LK_HIT:     paddr = lk_paddr;
          LK_CLEAN: begin
            fault = 1'b1;
            code  = EXC_CLEAN;
          end
          default: begin
            fault = 1'b1;
            code  = store ? EXC_TLB_S : EXC_TLB_L;
          end
        endcase
      end
    endcase
  end

  always_comb begin
    assert_code_zero_on_success_R8: assert (fault || code == EXC_NONE);
  end
endmodule

// File: rtl/seg_fault_regs.sv
module seg_fault_regs #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned ASID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_stb,
  input  logic [VA_W-1:0] fault_addr,
  input  logic            base_we,
  input  logic [VA_W-24:0] base_wdata,
  input  logic            asid_we,
  input  logic [ASID_W-1:0] asid_wdata,
  output logic [VA_W-1:0] badaddr,
  output logic [VA_W-1:0] context_w,
  output logic [VA_W-1:0] entryhi
);
  localparam int unsigned PAIR_LSB = 13;
  localparam int unsigned VPN2_W   = VA_W - PAIR_LSB;
  localparam int unsigned BASE_W   = VA_W - 23;
  localparam int unsigned EH_PAD   = PAIR_LSB - ASID_W;

  logic [VA_W-1:0]   bad_q, bad_d;
  logic [VPN2_W-1:0] vpn2_q, vpn2_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [ASID_W-1:0] asid_q, asid_d;

  always_comb begin
    bad_d  = bad_q;
    vpn2_d = vpn2_q;
    base_d = base_q;
    asid_d = asid_q;
    if (fault_stb) begin
      bad_d  = fault_addr;
      vpn2_d = fault_addr[VA_W-1:PAIR_LSB];
    end
    if (base_we) base_d = base_wdata;
    if (asid_we) asid_d = asid_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q  <= '0;
      vpn2_q <= '0;
      base_q <= '0;
      asid_q <= '0;
    end else begin
      bad_q  <= bad_d;
      vpn2_q <= vpn2_d;
      base_q <= base_d;
      asid_q <= asid_d;
    end
  end

  assign badaddr   = bad_q;
  assign context_w = {base_q, vpn2_q, 4'b0000};
  assign entryhi   = {vpn2_q, {EH_PAD{1'b0}}, asid_q};

  assert_bad_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stb |=> badaddr == $past(fault_addr));
  assert_hold_without_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_stb |=> $stable(badaddr) && $stable(entryhi[VA_W-1:PAIR_LSB]));
  assert_ctx_tracks_entryhi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    context_w[VA_W-BASE_W-1:4] == entryhi[VA_W-1:PAIR_LSB]);
  assert_asid_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !asid_we |=> $stable(entryhi[ASID_W-1:0]));
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_user,
  input  logic              req_error_lvl,
  input  logic              req_store,
  output logic              tlb_req_o,
  output logic [VA_W-1:0]   tlb_vaddr_o,
  input  logic [1:0]        tlb_status_i,
  input  logic [VA_W-1:0]   tlb_paddr_i,
  input  logic              ctx_base_we,
  input  logic [VA_W-24:0]  ctx_base_wdata,
  input  logic              asid_we,
  input  logic [ASID_W-1:0] asid_wdata,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [CODE_W-1:0] resp_code,
  output logic [VA_W-1:0]   resp_paddr,
  output logic [VA_W-1:0]   badaddr_o,
  output logic [VA_W-1:0]   context_o,
  output logic [VA_W-1:0]   entryhi_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  region_e           region;
  logic [VA_W-1:0]   direct_pa;
  logic              out_fault;
  logic [CODE_W-1:0] out_code;
  logic [VA_W-1:0]   out_pa;
  logic              fault_stb;

  seg_region_decode #(.VA_W(VA_W)) u_decode (
    .vaddr        (req_vaddr),
    .user         (req_user),
    .error_lvl    (req_error_lvl),
    .region       (region),
    .direct_paddr (direct_pa)
  );

  seg_outcome #(.VA_W(VA_W)) u_outcome (
    .region       (region),
    .store        (req_store),
    .direct_paddr (direct_pa),
    .lk_status    (tlb_status_i),
    .lk_paddr     (tlb_paddr_i),
    .fault        (out_fault),
    .code         (out_code),
    .paddr        (out_pa)
  );

  assign tlb_req_o   = req_valid && (region == REG_MAPPED);
  assign tlb_vaddr_o = req_vaddr;
  assign fault_stb   = req_valid && out_fault;

  seg_fault_regs #(.VA_W(VA_W), .ASID_W(ASID_W)) u_fregs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .fault_stb  (fault_stb),
    .fault_addr (req_vaddr),
    .base_we    (ctx_base_we),
    .base_wdata (ctx_base_wdata),
    .asid_we    (asid_we),
    .asid_wdata (asid_wdata),
    .badaddr    (badaddr_o),
    .context_w  (context_o),
    .entryhi    (entryhi_o)
  );

  // response stage: next-state and register processes
  logic              rv_d, rv_q, rf_d, rf_q;
  logic [CODE_W-1:0] rc_d, rc_q;
  logic [VA_W-1:0]   rp_d, rp_q;
  logic              resp_en;

  assign resp_en = req_valid || rv_q;

  always_comb begin
    rv_d = req_valid;
    rf_d = req_valid && out_fault;
    rc_d = req_valid ? out_code : EXC_NONE;
    rp_d = req_valid ? out_pa : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rv_q <= 1'b0;
      rf_q <= 1'b0;
      rc_q <= '0;
      rp_q <= '0;
    end else if (resp_en) begin
      rv_q <= rv_d;
      rf_q <= rf_d;
      rc_q <= rc_d;
      rp_q <= rp_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_fault = rf_q;
  assign resp_code  = rc_q;
  assign resp_paddr = rp_q;

  assert_user_high_adr_err_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_user && req_vaddr[VA_W-1]) |=>
      resp_fault && (resp_code == EXC_ADR_L || resp_code == EXC_ADR_S));
  assert_no_lookup_user_high_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_user && req_vaddr[VA_W-1]) |-> !tlb_req_o);
  assert_resp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> resp_valid);
  assert_fault_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    resp_fault |-> resp_valid && resp_paddr == '0);
  assert_lookup_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    tlb_req_o |-> req_valid);
endmodule

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_user = 1'b0, req_error_lvl = 1'b0, req_store = 1'b0;
  logic        tlb_req_o;
  logic [31:0] tlb_vaddr_o;
  logic [1:0]  tlb_status_i = 2'b00;
  logic [31:0] tlb_paddr_i = '0;
  logic        ctx_base_we = 1'b0;
  logic [8:0]  ctx_base_wdata = '0;
  logic        asid_we = 1'b0;
  logic [7:0]  asid_wdata = '0;
  logic        resp_valid, resp_fault;
  logic [4:0]  resp_code;
  logic [31:0] resp_paddr, badaddr_o, context_o, entryhi_o;

  always #2 clk = ~clk;

  seg_xlate_unit i_seg_xlate_unit (.*);

  int total = 0;
  int bad = 0;
  logic [31:0] m_bad = '0;
  logic [18:0] m_vpn = '0;
  logic [8:0]  m_base = '0;
  logic [7:0]  m_asid = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " badaddr"}, badaddr_o, m_bad);
    chk({tag, " context"}, context_o, {m_base, m_vpn, 4'b0000});
    chk({tag, " entryhi"}, entryhi_o, {m_vpn, 5'b00000, m_asid});
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        user;
    logic        erl;
    logic        st;
    logic [1:0]  lk;
    logic [31:0] lpa;
    logic        x_req;
    logic        x_fault;
    logic [4:0]  x_code;
    logic [31:0] x_pa;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_1234, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0012_3234, 1'b1, 1'b0, 5'd0, 32'h0012_3234, 4'd2},  // R2 R6 hit
    '{32'h8000_0010, 1'b1, 1'b0, 1'b0, 2'b00, 32'h0,        1'b0, 1'b1, 5'd4, 32'h0,        4'd1},  // R1 load
    '{32'hC000_2000, 1'b1, 1'b0, 1'b1, 2'b00, 32'h0,        1'b0, 1'b1, 5'd5, 32'h0,        4'd1},  // R1 store
    '{32'h9FFF_FFFC, 1'b0, 1'b0, 1'b0, 2'b01, 32'h0,        1'b0, 1'b0, 5'd0, 32'h1FFF_FFFC, 4'd4}, // R4 status ignored
    '{32'hA000_0100, 1'b0, 1'b0, 1'b1, 2'b11, 32'h0,        1'b0, 1'b0, 5'd0, 32'h0000_0100, 4'd4}, // R4
    '{32'hBFC0_0000, 1'b0, 1'b0, 1'b1, 2'b10, 32'h0,        1'b0, 1'b0, 5'd0, 32'h1FC0_0000, 4'd4}, // R4 top edge
    '{32'h7FFF_E000, 1'b0, 1'b1, 1'b0, 2'b01, 32'h0,        1'b0, 1'b0, 5'd0, 32'h7FFF_E000, 4'd3}, // R3
    '{32'h1234_5678, 1'b0, 1'b0, 1'b0, 2'b01, 32'h0,        1'b1, 1'b1, 5'd2, 32'h0,        4'd6},  // R6 nomatch load
    '{32'h1234_5678, 1'b0, 1'b0, 1'b1, 2'b01, 32'h0,        1'b1, 1'b1, 5'd3, 32'h0,        4'd6},  // R6 nomatch store
    '{32'hC000_4000, 1'b0, 1'b0, 1'b1, 2'b10, 32'h0,        1'b1, 1'b1, 5'd3, 32'h0,        4'd5},  // R5 R6 invalid store
    '{32'hE000_0ABC, 1'b0, 1'b0, 1'b0, 2'b10, 32'h0,        1'b1, 1'b1, 5'd2, 32'h0,        4'd5},  // R5 invalid load
    '{32'hF00D_3008, 1'b0, 1'b0, 1'b1, 2'b11, 32'h0,        1'b1, 1'b1, 5'd1, 32'h0,        4'd7},  // R7
    '{32'hC000_0000, 1'b0, 1'b0, 1'b1, 2'b00, 32'h0AB0_0000, 1'b1, 1'b0, 5'd0, 32'h0AB0_0000, 4'd5}, // R5 low edge
    '{32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 2'b00, 32'h0000_0055, 1'b1, 1'b0, 5'd0, 32'h0000_0055, 4'd2}, // R2 user low
    '{32'h0000_0040, 1'b1, 1'b1, 1'b0, 2'b11, 32'h0,        1'b0, 1'b0, 5'd0, 32'h0000_0040, 4'd3}  // R3 user
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R13 reset state
    chk("R13 resp_valid", {31'b0, resp_valid}, 32'h0);
    chk_regs("R13");

    // configuration writes (R10, R11)
    @(negedge clk);
    ctx_base_we = 1'b1; ctx_base_wdata = 9'h15A;
    asid_we = 1'b1;     asid_wdata = 8'h3C;
    @(negedge clk);
    ctx_base_we = 1'b0; asid_we = 1'b0;
    m_base = 9'h15A; m_asid = 8'h3C;
    #1;
    chk_regs("R10 R11 config");

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = VECS[i].va;
      req_user = VECS[i].user;
      req_error_lvl = VECS[i].erl;
      req_store = VECS[i].st;
      tlb_status_i = VECS[i].lk;
      tlb_paddr_i = VECS[i].lpa;
      #1;
      chk({tg, " tlb_req"}, {31'b0, tlb_req_o}, {31'b0, VECS[i].x_req});
      if (VECS[i].x_req) chk({tg, " tlb_vaddr"}, tlb_vaddr_o, VECS[i].va);
      @(posedge clk);
      #1;
      chk({tg, " R8 valid"}, {31'b0, resp_valid}, 32'h1);
      chk({tg, " fault"}, {31'b0, resp_fault}, {31'b0, VECS[i].x_fault});
      chk({tg, " code"}, {27'b0, resp_code}, {27'b0, VECS[i].x_code});
      chk({tg, " paddr"}, resp_paddr, VECS[i].x_pa);
      if (VECS[i].x_fault) begin
        m_bad = VECS[i].va;        // R9
        m_vpn = VECS[i].va[31:13]; // R10 R11
      end
      chk_regs({tg, " R12 regs"});
      @(negedge clk);
      req_valid = 1'b0;
    end

    // R8: idle cycle gives no response
    @(posedge clk);
    #1;
    chk("R8 idle valid", {31'b0, resp_valid}, 32'h0);

    // R12: a failing address without req_valid changes nothing
    @(negedge clk);
    req_valid = 1'b0; req_user = 1'b1; req_vaddr = 32'hDEAD_B000; req_store = 1'b1;
    #1;
    chk("R12 no lookup when idle", {31'b0, tlb_req_o}, 32'h0);
    @(posedge clk);
    #1;
    chk("R12 idle no resp", {31'b0, resp_valid}, 32'h0);
    chk_regs("R12 idle");

    // R11: identifier rewrite keeps the fault-loaded page pair
    @(negedge clk);
    asid_we = 1'b1; asid_wdata = 8'hA5;
    @(negedge clk);
    asid_we = 1'b0; m_asid = 8'hA5;
    #1;
    chk_regs("R11 asid rewrite");

    // R9 R10 R11: fault with config write on the same edge
    @(negedge clk);
    req_valid = 1'b1; req_user = 1'b0; req_error_lvl = 1'b0; req_store = 1'b0;
    req_vaddr = 32'h3FFF_FFFF; tlb_status_i = 2'b10;
    ctx_base_we = 1'b1; ctx_base_wdata = 9'h0F0;
    @(posedge clk);
    #1;
    m_bad = 32'h3FFF_FFFF; m_vpn = 19'h1FFFF; m_base = 9'h0F0;
    chk("R6 invalid load code", {27'b0, resp_code}, 32'd2);
    chk_regs("R9 R10 R11 same-edge");
    @(negedge clk);
    req_valid = 1'b0; ctx_base_we = 1'b0;
    repeat (2) @(posedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule